// File: doc/BRIEF.md
# Write Status Readout Multiplexer

This block sits on the read path of a byte-wide nonvolatile memory that becomes busy while it writes. When the memory is idle, a read returns the byte fetched from the array. Once at least one byte has been loaded, the memory enters a write cycle: first a page-load window, then internal programming. During that cycle a read returns a status byte instead of array data. Bit 7 is a polarity flag derived from the last loaded byte. Bit 6 flips on every read. Bit 5 tells the loading phase apart from the programming phase. The remaining bits are left undriven.

The write controller supplies two flags: one for the load window being open and one for programming being underway. It also supplies the most recently loaded byte. The array supplies its read data. The block produces a data bus with a per-bit drive enable and an active-low busy indication. Every output is registered, so each output reflects the inputs sampled at the previous rising clock edge.

Top module: `wsr_status_readout`

## Requirements
- R1: While a write cycle is active (load window open or programming), a read drives bit 7 with the complement of bit 7 of the last loaded byte. Once the cycle has ended, a read returns the array byte unaltered.
- R2: Within a write cycle, bit 6 of the status byte changes value at each new rising edge of the read condition. It holds its value for as long as the read condition stays asserted.
- R3: During a write cycle, status bit 5 reads 0 while only the load window is open and reads 1 while programming is active.
- R4: During a write cycle, bits 4 down to 0 have their drive enables low, even while reading.
- R5: With no write cycle active, a read drives all 8 bits with the array read data.
- R6: busy_n_o is 0 in the cycle after programming is sampled active and 1 otherwise.
- R7: The bus is driven only when chip enable and output enable are asserted and write enable is not. Otherwise every drive enable is 0.
- R8: The first status read after the start of each new write cycle returns 0 on bit 6, whatever the toggle state left by an earlier cycle.
- R9: During reset, dq_o is 0, dq_en_o is 0 and busy_n_o is 1.
- R10: Every output follows its inputs with exactly one clock of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip enable asserted (active high) |
| oe_i | input | 1 | Output enable asserted (active high) |
| we_i | input | 1 | Write enable asserted (active high) |
| ld_tmr_i | input | 1 | Page-load window timer running |
| prog_i | input | 1 | Internal programming in progress |
| last_wr_i | input | 8 | Most recently loaded data byte |
| arr_rd_i | input | 8 | Array read data for the addressed byte |
| dq_o | output | 8 | Read data bus value |
| dq_en_o | output | 8 | Per-bit drive enable of the data bus |
| busy_n_o | output | 1 | Low while programming is in progress |

## Verification
The assertions check on every cycle the properties that hold one cycle at a time:
- the polarity of bit 7 and the phase flag on bit 5;
- the quiet low bits;
- the drive gating, the pass-through of array data when idle, and the busy output;
- the rule that bit 6 holds still while a read stays asserted.

The alternation of bit 6 across separate reads, its restart at 0 at each new cycle, and its survival through gaps between reads depend on a history of several reads. Only the bench's directed scenarios and its cycle-by-cycle model show those.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

   typedef enum logic [1:0] {
      ROLE_POLL,
      ROLE_TOGGLE,
      ROLE_PHASE,
      ROLE_QUIET
   } bit_role_e;

   function automatic bit_role_e role_of(input int idx, input int poll_b,
                                         input int tog_b, input int phase_b);
      if (idx == poll_b)       return ROLE_POLL;
      else if (idx == tog_b)   return ROLE_TOGGLE;
      else if (idx == phase_b) return ROLE_PHASE;
      else                     return ROLE_QUIET;
   endfunction

endpackage

// File: rtl/wsr_strobe.sv
module wsr_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_i,
   input  logic oe_i,
   input  logic we_i,
   output logic rd_lvl_o,
   output logic rd_edge_o
);
   logic rd_q;

   assign rd_lvl_o  = ce_i & oe_i & ~we_i;
   assign rd_edge_o = rd_lvl_o & ~rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= 1'b0;
      else        rd_q <= rd_lvl_o;
   end
endmodule

// File: rtl/wsr_toggle.sv
module wsr_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_i,
   input  logic rd_edge_i,
   output logic view_d_o
);
   logic cyc_q, tog_q, view_q;
   logic start, adv, tog_base;

   assign start    = cyc_i & ~cyc_q;
   assign adv      = cyc_i & rd_edge_i;
   assign tog_base = start ? 1'b0 : tog_q;
   assign view_d_o = adv ? tog_base : (start ? 1'b0 : view_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_q  <= 1'b0;
         tog_q  <= 1'b0;
         view_q <= 1'b0;
      end else begin
         cyc_q  <= cyc_i;
         view_q <= view_d_o;
         tog_q  <= adv ? ~tog_base : tog_base;
      end
   end
endmodule

// File: rtl/wsr_bus_mux.sv
module wsr_bus_mux
   import wsr_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int POLL_B  = 7,
   parameter int TOG_B   = 6,
   parameter int PHASE_B = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_lvl_i,
   input  logic              cyc_i,
   input  logic              prog_i,
   input  logic              poll_src_i,
   input  logic              tog_view_i,
   input  logic [DATA_W-1:0] arr_rd_i,
   output logic [DATA_W-1:0] dq_o,
   output logic [DATA_W-1:0] dq_en_o
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      localparam bit_role_e ROLE = role_of(b, POLL_B, TOG_B, PHASE_B);
      logic stat_val, stat_drv, val_q, en_q;

      if (ROLE == ROLE_POLL) begin : g_poll
         assign stat_val = ~poll_src_i;
         assign stat_drv = 1'b1;
      end else if (ROLE == ROLE_TOGGLE) begin : g_tog
         assign stat_val = tog_view_i;
         assign stat_drv = 1'b1;
      end else if (ROLE == ROLE_PHASE) begin : g_phase
         assign stat_val = prog_i;
         assign stat_drv = 1'b1;
      end else begin : g_quiet
         assign stat_val = 1'b0;
         assign stat_drv = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q <= 1'b0;
            en_q  <= 1'b0;
         end else begin
            val_q <= cyc_i ? stat_val : arr_rd_i[b];
            en_q  <= rd_lvl_i & (cyc_i ? stat_drv : 1'b1);
         end
      end

      assign dq_o[b]    = val_q;
      assign dq_en_o[b] = en_q;
   end
endmodule

// File: rtl/wsr_status_readout.sv
module wsr_status_readout #(
   parameter int DATA_W  = 8,
   parameter int POLL_B  = 7,
   parameter int TOG_B   = 6,
   parameter int PHASE_B = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_i,
   input  logic              oe_i,
   input  logic              we_i,
   input  logic              ld_tmr_i,
   input  logic              prog_i,
   input  logic [DATA_W-1:0] last_wr_i,
   input  logic [DATA_W-1:0] arr_rd_i,
   output logic [DATA_W-1:0] dq_o,
   output logic [DATA_W-1:0] dq_en_o,
   output logic              busy_n_o
);
   localparam int MAX_B = DATA_W - 1;

   initial begin
      assert (DATA_W >= 3) else $error("DATA_W must hold three status bits");
      assert (POLL_B <= MAX_B && TOG_B <= MAX_B && PHASE_B <= MAX_B)
         else $error("status bit index out of range");
      assert (POLL_B != TOG_B && POLL_B != PHASE_B && TOG_B != PHASE_B)
         else $error("status bit indices must differ");
   end

   logic rd_lvl, rd_edge, cyc, tog_view, busy_n_q;
   logic unused_last_wr;

   assign cyc            = ld_tmr_i | prog_i;
   assign unused_last_wr = ^last_wr_i;

   wsr_strobe u_strobe (
      .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .oe_i(oe_i), .we_i(we_i),
      .rd_lvl_o(rd_lvl), .rd_edge_o(rd_edge)
   );

   wsr_toggle u_toggle (
      .clk(clk), .rst_n(rst_n), .cyc_i(cyc), .rd_edge_i(rd_edge),
      .view_d_o(tog_view)
   );

   wsr_bus_mux #(
      .DATA_W(DATA_W), .POLL_B(POLL_B), .TOG_B(TOG_B), .PHASE_B(PHASE_B)
   ) u_mux (
      .clk(clk), .rst_n(rst_n), .rd_lvl_i(rd_lvl), .cyc_i(cyc),
      .prog_i(prog_i), .poll_src_i(last_wr_i[POLL_B]),
      .tog_view_i(tog_view), .arr_rd_i(arr_rd_i),
      .dq_o(dq_o), .dq_en_o(dq_en_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_n_q <= 1'b1;
      else        busy_n_q <= ~prog_i;
   end

   assign busy_n_o = busy_n_q;
endmodule

// File: rtl/wsr_checker.sv
module wsr_checker #(
   parameter int DATA_W  = 8,
   parameter int POLL_B  = 7,
   parameter int TOG_B   = 6,
   parameter int PHASE_B = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ce_i,
   input logic              oe_i,
   input logic              we_i,
   input logic              ld_tmr_i,
   input logic              prog_i,
   input logic [DATA_W-1:0] last_wr_i,
   input logic [DATA_W-1:0] arr_rd_i,
   input logic [DATA_W-1:0] dq_o,
   input logic [DATA_W-1:0] dq_en_o,
   input logic              busy_n_o
);
   logic rd, cyc;
   assign rd  = ce_i & oe_i & ~we_i;
   assign cyc = ld_tmr_i | prog_i;

   AST_POLL_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd) && $past(cyc)) |-> (dq_o[POLL_B] == ~$past(last_wr_i[POLL_B]))); // R1
   AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd) && $past(rd, 2) && $past(cyc) && $past(cyc, 2)) |-> $stable(dq_o[TOG_B])); // R2
   AST_PHASE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd) && $past(cyc)) |-> (dq_o[PHASE_B] == $past(prog_i))); // R3
   AST_QUIET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cyc) |-> ($countones(dq_en_o) <= 3)); // R4
   AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd) && !$past(cyc)) |-> (dq_o == $past(arr_rd_i) && (&dq_en_o))); // R5
   AST_BUSY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      busy_n_o == !$past(prog_i)); // R6
   AST_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd) |-> (dq_en_o == '0)); // R7
endmodule

bind wsr_status_readout wsr_checker #(
   .DATA_W(DATA_W), .POLL_B(POLL_B), .TOG_B(TOG_B), .PHASE_B(PHASE_B)
) u_chk (
   .clk(clk), .rst_n(rst_n), .ce_i(ce_i), .oe_i(oe_i), .we_i(we_i),
   .ld_tmr_i(ld_tmr_i), .prog_i(prog_i), .last_wr_i(last_wr_i),
   .arr_rd_i(arr_rd_i), .dq_o(dq_o), .dq_en_o(dq_en_o), .busy_n_o(busy_n_o)
);

// File: tb/wsr_status_readout_bench.sv
module wsr_status_readout_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ce = 0, oe = 0, we = 0, ld = 0, prog = 0;
   logic [7:0] lw = 8'h00, arr = 8'h00;
   logic [7:0] dq, dq_en;
   logic busy_n;

   int checks = 0, errs = 0;
   bit done = 0, mon_on = 0;

   always #2 clk = ~clk;

   wsr_status_readout u_wsr_status_readout (
      .clk(clk), .rst_n(rst_n), .ce_i(ce), .oe_i(oe), .we_i(we),
      .ld_tmr_i(ld), .prog_i(prog), .last_wr_i(lw), .arr_rd_i(arr),
      .dq_o(dq), .dq_en_o(dq_en), .busy_n_o(busy_n)
   );

   // behavioural reference model
   logic [7:0] exp_dq, exp_en;
   logic exp_busy, m_prev_cyc, m_prev_rd, m_stat, m_view;
   int m_reads;

   always @(posedge clk) begin
      logic rd, cyc;
      if (!rst_n) begin
         exp_dq = 0; exp_en = 0; exp_busy = 1; m_prev_cyc = 0; m_prev_rd = 0;
         m_stat = 0; m_view = 0; m_reads = 0;
      end else begin
         rd = ce && oe && !we;
         cyc = ld || prog;
         if (cyc && !m_prev_cyc) begin m_reads = 0; m_view = 0; end
         if (cyc && rd && !m_prev_rd) begin m_view = m_reads[0]; m_reads++; end
         exp_busy = !prog;
         if (cyc) begin
            exp_dq = {~lw[7], m_view, prog, 5'b0};
            exp_en = rd ? 8'hE0 : 8'h00;
         end else begin
            exp_dq = arr;
            exp_en = rd ? 8'hFF : 8'h00;
         end
         m_prev_cyc = cyc; m_prev_rd = rd; m_stat = cyc;
      end
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && mon_on) begin
         chk("R6 busy", {7'b0, busy_n}, {7'b0, exp_busy});
         chk(m_stat ? "R4 enables" : "R7 enables", dq_en, exp_en);
         if (exp_en != 0) begin
            if (m_stat) begin
               chk("R1 bit7", {7'b0, dq[7]}, {7'b0, exp_dq[7]});
               chk("R2 bit6", {7'b0, dq[6]}, {7'b0, exp_dq[6]});
               chk("R3 bit5", {7'b0, dq[5]}, {7'b0, exp_dq[5]});
            end else begin
               chk("R5 data R10", dq, exp_dq);
            end
         end
      end
   end

   task automatic tick(input int n = 1);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   // one read pulse; returns bit 6 sampled after the registered output settles
   task automatic read_pulse(output logic b6);
      ce = 1; oe = 1; we = 0;
      tick();
      @(negedge clk); b6 = dq[6];
      tick();
      oe = 0;
      tick();
   endtask

   initial begin
      logic b;
      tick(3);
      @(negedge clk);
      chk("R9 dq", dq, 8'h00);
      chk("R9 en", dq_en, 8'h00);
      chk("R9 busy", {7'b0, busy_n}, 8'h01);
      @(posedge clk); #1 rst_n = 1; mon_on = 1;

      // idle reads
      arr = 8'h5A; ce = 1; oe = 1; tick();
      @(negedge clk); chk("R5 idle read", dq, 8'h5A);
      arr = 8'hC3; tick();
      @(negedge clk); chk("R10 one-cycle follow", dq, 8'hC3);
      we = 1; tick();
      @(negedge clk); chk("R7 write blocks drive", dq_en, 8'h00);
      we = 0; ce = 0; tick(2);

      // load window open, last byte 0x80
      lw = 8'h80; ld = 1; tick(2);
      read_pulse(b); chk("R2 first read", {7'b0, b}, 8'h00);
      read_pulse(b); chk("R2 second read", {7'b0, b}, 8'h01);
      ce = 1; oe = 1; tick();
      @(negedge clk); chk("R4 quiet bits", dq_en, 8'hE0);
      chk("R1 inverted poll", {7'b0, dq[7]}, 8'h00);
      chk("R3 load phase", {7'b0, dq[5]}, 8'h00);
      tick(4);
      @(negedge clk); chk("R2 held while read", {7'b0, dq[6]}, 8'h00);
      oe = 0; tick();

      // programming phase
      ld = 0; prog = 1; tick();
      @(negedge clk); chk("R6 busy low", {7'b0, busy_n}, 8'h00);
      read_pulse(b); chk("R2 fourth read", {7'b0, b}, 8'h01);
      ce = 1; oe = 1; tick();
      @(negedge clk); chk("R3 program phase", {7'b0, dq[5]}, 8'h01);
      oe = 0; tick();

      // completion
      prog = 0; arr = 8'h80; tick();
      @(negedge clk); chk("R6 busy released", {7'b0, busy_n}, 8'h01);
      oe = 1; tick();
      @(negedge clk); chk("R1 true value after cycle", dq, 8'h80);
      oe = 0; tick(2);

      // new cycle restarts toggle
      lw = 8'h3C; prog = 1; tick();
      read_pulse(b); chk("R8 restart at 0", {7'b0, b}, 8'h00);
      ce = 1; oe = 1; tick();
      @(negedge clk); chk("R1 poll of 0x3C", {7'b0, dq[7]}, 8'h01);
      we = 1; tick();
      @(negedge clk); chk("R7 write in cycle", dq_en, 8'h00);
      we = 0; oe = 0; prog = 0; ce = 0; tick(3);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog all requirements act=hung exp=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule